// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Frame Swap Controller

This block decides when the two halves of a double-buffered frame store trade roles. A pixel producer writes into one bank in its own clock domain. A display consumer reads the other bank in a second, unrelated clock domain. The block counts accepted pixel writes and raises a held "frame ready" level once a whole frame sits in the write bank. That level crosses into the read domain through a two-stage synchronizer.

When the display asks for its next frame, the read side swaps banks only if a complete frame is waiting. If none is waiting, it keeps showing the current bank. A swap raises a one-cycle pulse that loads a shift register with ones. The OR of that register is a stretched acknowledge level. The write domain synchronizes this level and uses its rising edge to clear the ready flag and move the writer to the bank the reader just released.

The block outputs bank selects and base offsets for both sides. The RAM itself lives outside.

Top module: `frame_swap_ctrl`

## Requirements
- R1: After reset, `rd_bank` is 0 and `rd_base` is 0. `wr_bank` is 1 and `wr_addr` equals FRAME_PIXELS (the base of bank 1). `wr_frame_full` and `rd_swap` are 0, and `wr_ready` is 1.
- R2: Each cycle with `wr_pix_valid` and `wr_ready` both high writes to `wr_addr`, then advances it by one. Addresses run from the write bank base (bank × FRAME_PIXELS). After FRAME_PIXELS accepted writes, `wr_frame_full` is 1 and `wr_ready` is 0 on the next write clock.
- R3: While `wr_frame_full` is 1, pixel strobes are ignored: `wr_addr` does not move and the flag stays set.
- R4: A `rd_frame_req` that finds the synchronized ready flag high toggles `rd_bank` at the next read edge. `rd_base` then becomes `rd_bank` × FRAME_PIXELS, and `rd_swap` is high for exactly one cycle.
- R5: A `rd_frame_req` when no full frame is waiting leaves `rd_bank` and `rd_base` unchanged and does not pulse `rd_swap`.
- R6: After a swap, `wr_frame_full` clears within a few write clocks. At the same edge, `wr_bank` becomes the opposite of `rd_bank` and `wr_addr` restarts at that bank's base.
- R7: After the flag clears, `wr_ready` stays 0 until the synchronized acknowledge has fallen. Only then are new pixels accepted, so no frame is re-signalled under the old acknowledge.
- R8: While the stretched acknowledge (16 read cycles) is still active, a further `rd_frame_req` causes no swap.
- R9: The ready flag is seen by the read side within two read clocks of its rise. A request issued at least three read clocks later swaps.
- R10: Each reset is synchronous and acts on its own domain only. Resetting the write side mid-frame returns `wr_addr` to the bank-1 base and leaves `rd_bank` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer clock |
| wr_rst | input | 1 | Synchronous reset, write domain |
| wr_pix_valid | input | 1 | Pixel write strobe from the producer |
| wr_ready | output | 1 | Writer may store a pixel this cycle |
| wr_addr | output | ADDR_W | RAM write address (bank base plus pixel count) |
| wr_bank | output | 1 | Bank currently being filled |
| wr_frame_full | output | 1 | Complete frame waiting in the write bank |
| rd_clk | input | 1 | Display clock |
| rd_rst | input | 1 | Synchronous reset, read domain |
| rd_frame_req | input | 1 | Display asks for its next frame |
| rd_swap | output | 1 | One-cycle pulse on an accepted swap |
| rd_bank | output | 1 | Bank being displayed |
| rd_base | output | ADDR_W | Base address of the displayed bank |

## Verification
A corrupt pixel counter or bank bit shows up at once on `wr_addr`, one write clock after the bad state. It is caught against the expected base-plus-index sequence. A stuck or lost acknowledge shows up as `wr_frame_full` never clearing within the bounded wait, or as the writer resuming before the acknowledge falls. A mis-sampled ready flag appears as a missing or doubled `rd_swap` on the read clock right after the request. Requests in the stretch window and with no waiting frame show whether the read bank moves when it must not.

// File: rtl/frame_swap_ctrl.sv
module frame_swap_ctrl #(
  parameter int FRAME_PIXELS = 64,
  parameter int STRETCH_LEN  = 16,
  parameter int ADDR_W       = $clog2(2 * FRAME_PIXELS)
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_pix_valid,
  output logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_bank,
  output logic              wr_frame_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_frame_req,
  output logic              rd_swap,
  output logic              rd_bank,
  output logic [ADDR_W-1:0] rd_base
);

  localparam int CNT_W = (FRAME_PIXELS > 1) ? $clog2(FRAME_PIXELS) : 1;
  localparam logic [ADDR_W-1:0] BANK1_BASE = ADDR_W'(FRAME_PIXELS);
  localparam logic [CNT_W-1:0]  LAST_PIX   = CNT_W'(FRAME_PIXELS - 1);

  // ---------------- write domain ----------------
  logic [CNT_W-1:0] pix_cnt;
  logic             ack_s0, ack_s1, ack_d;
  logic             ack_rise, accept;

  // stretch register and its OR live in the read domain
  logic [STRETCH_LEN-1:0] stretch;
  logic                   ack_lvl;

  assign ack_lvl  = |stretch;
  assign ack_rise = ack_s1 & ~ack_d;
  assign wr_ready = ~wr_frame_full & ~ack_s1;
  assign accept   = wr_pix_valid & wr_ready;
  assign wr_addr  = (wr_bank ? BANK1_BASE : '0) + ADDR_W'(pix_cnt);

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      ack_s0 <= 1'b0;
      ack_s1 <= 1'b0;
      ack_d  <= 1'b0;
    end else begin
      ack_s0 <= ack_lvl;
      ack_s1 <= ack_s0;
      ack_d  <= ack_s1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      pix_cnt       <= '0;
      wr_frame_full <= 1'b0;
      wr_bank       <= 1'b1;
    end else if (ack_rise) begin
      wr_frame_full <= 1'b0;
      wr_bank       <= ~wr_bank;
      pix_cnt       <= '0;
    end else if (accept) begin
      if (pix_cnt == LAST_PIX) begin
        pix_cnt       <= '0;
        wr_frame_full <= 1'b1;
      end else begin
        pix_cnt <= pix_cnt + 1'b1;
      end
    end
  end

  a_r2_full_after_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $rose(wr_frame_full) |-> $past(wr_pix_valid && wr_ready));

  a_r3_hold_when_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_frame_full && !ack_rise) |=> ($stable(wr_addr) && wr_frame_full));

  a_r6_bank_moves_on_clear: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_bank != $past(wr_bank)) |-> $fell(wr_frame_full));

  a_r2_count_in_range: assert property (@(posedge wr_clk) disable iff (wr_rst)
    pix_cnt <= LAST_PIX);

  // ---------------- read domain ----------------
  logic full_s0, full_s1, do_swap;

  assign do_swap = rd_frame_req & full_s1 & ~ack_lvl;
  assign rd_base = rd_bank ? BANK1_BASE : '0;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      full_s0 <= 1'b0;
      full_s1 <= 1'b0;
      rd_bank <= 1'b0;
      rd_swap <= 1'b0;
      stretch <= '0;
    end else begin
      full_s0 <= wr_frame_full;
      full_s1 <= full_s0;
      rd_swap <= do_swap;
      if (do_swap) begin
        rd_bank <= ~rd_bank;
        stretch <= '1;
      end else begin
        stretch <= {stretch[STRETCH_LEN-2:0], 1'b0};
      end
    end
  end

  a_r4_bank_change_has_pulse: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_bank != $past(rd_bank)) |-> rd_swap);

  a_r4_pulse_single: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_swap |=> !rd_swap);

  a_r5_no_swap_without_frame: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_frame_req && !full_s1) |=> !rd_swap);

  a_r8_no_swap_in_window: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_swap |-> ($past(stretch) == '0 && ack_lvl));

endmodule

// File: tb/frame_swap_ctrl_tb.sv
`timescale 1ns/1ps
module frame_swap_ctrl_tb;
  localparam int F = 8;
  localparam int AW = $clog2(2 * F);

  logic rd_clk = 0, wr_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic wr_pix_valid = 0, rd_frame_req = 0;
  logic wr_ready, wr_bank, wr_frame_full, rd_swap, rd_bank;
  logic [AW-1:0] wr_addr, rd_base;

  int n_tests = 0, n_fail = 0;
  int rd_cycles = 0;

  always #2.0 rd_clk = ~rd_clk;
  always #3.7 wr_clk = ~wr_clk;

  frame_swap_ctrl #(.FRAME_PIXELS(F), .STRETCH_LEN(16)) u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_pix_valid(wr_pix_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_bank(wr_bank),
    .wr_frame_full(wr_frame_full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_frame_req(rd_frame_req),
    .rd_swap(rd_swap), .rd_bank(rd_bank), .rd_base(rd_base));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge rd_clk) begin
    rd_cycles++;
    if (rd_cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd_cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic t_reset();
    repeat (4) @(negedge wr_clk);
    wr_rst = 0;
    @(negedge rd_clk);
    rd_rst = 0;
    @(negedge wr_clk);
    @(negedge rd_clk);
    chk(rd_bank == 0, "R1 rd_bank", rd_bank, 0);
    chk(rd_base == 0, "R1 rd_base", rd_base, 0);
    chk(wr_bank == 1, "R1 wr_bank", wr_bank, 1);
    chk(wr_addr == F, "R1 wr_addr", wr_addr, F);
    chk(wr_frame_full == 0 && rd_swap == 0, "R1 flags", wr_frame_full + rd_swap, 0);
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
  endtask

  task automatic t_fill(input int bank);
    for (int i = 0; i < F; i++) begin
      @(negedge wr_clk);
      chk(wr_addr == bank * F + i, "R2 write address", wr_addr, bank * F + i);
      wr_pix_valid = 1;
    end
    @(negedge wr_clk);
    wr_pix_valid = 0;
    chk(wr_frame_full == 1, "R2 full flag", wr_frame_full, 1);
    chk(wr_ready == 0, "R2 ready dropped", wr_ready, 0);
  endtask

  task automatic t_ignore();
    logic [AW-1:0] a;
    a = wr_addr;
    wr_pix_valid = 1;
    repeat (3) @(negedge wr_clk);
    wr_pix_valid = 0;
    chk(wr_addr == a, "R3 addr held", wr_addr, a);
    chk(wr_frame_full == 1, "R3 flag held", wr_frame_full, 1);
  endtask

  task automatic t_swap(input int exp_bank);
    repeat (3) @(negedge rd_clk);   // R9: three read clocks after the flag
    rd_frame_req = 1;
    @(negedge rd_clk);
    rd_frame_req = 0;
    chk(rd_swap == 1, "R4/R9 swap pulse", rd_swap, 1);
    chk(rd_bank == exp_bank, "R4 rd_bank", rd_bank, exp_bank);
    chk(rd_base == exp_bank * F, "R4 rd_base", rd_base, exp_bank * F);
    rd_frame_req = 1;               // R8: request inside the window
    @(negedge rd_clk);
    rd_frame_req = 0;
    chk(rd_swap == 0, "R4 pulse one cycle", rd_swap, 0);
    @(negedge rd_clk);
    chk(rd_swap == 0 && rd_bank == exp_bank, "R8 no second swap", rd_bank, exp_bank);
  endtask

  task automatic t_clear();
    int waited = 0;
    while (wr_frame_full && waited < 30) begin
      @(negedge wr_clk);
      waited++;
    end
    chk(wr_frame_full == 0, "R6 flag cleared", wr_frame_full, 0);
    chk(wr_bank == !rd_bank, "R6 wr_bank opposite", wr_bank, !rd_bank);
    chk(wr_addr == wr_bank * F, "R6 addr restart", wr_addr, wr_bank * F);
    chk(wr_ready == 0, "R7 held while ack high", wr_ready, 0);
    waited = 0;
    while (!wr_ready && waited < 40) begin
      @(negedge wr_clk);
      waited++;
    end
    chk(wr_ready == 1, "R7 ready after ack falls", wr_ready, 1);
    chk(wr_frame_full == 0, "R7 no re-signal", wr_frame_full, 0);
  endtask

  task automatic t_noswap();
    int b = rd_bank;
    @(negedge rd_clk);
    rd_frame_req = 1;
    @(negedge rd_clk);
    rd_frame_req = 0;
    chk(rd_swap == 0, "R5 no pulse", rd_swap, 0);
    chk(rd_bank == b && rd_base == b * F, "R5 bank kept", rd_bank, b);
  endtask

  task automatic t_wr_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge wr_clk);
      wr_pix_valid = 1;
    end
    @(negedge wr_clk);
    wr_pix_valid = 0;
    wr_rst = 1;
    @(negedge wr_clk);
    wr_rst = 0;
    chk(wr_addr == F && wr_bank == 1, "R10 write side reset", wr_addr, F);
    chk(wr_frame_full == 0, "R10 flag low", wr_frame_full, 0);
    @(negedge rd_clk);
    chk(rd_bank == 0, "R10 read side untouched", rd_bank, 0);
  endtask

  initial begin
    t_reset();
    t_noswap();
    t_fill(1);
    t_ignore();
    t_swap(1);
    t_clear();
    t_fill(0);
    t_swap(0);
    t_clear();
    repeat (10) @(negedge rd_clk);
    t_noswap();
    t_wr_reset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule